// File: doc/BRIEF.md
# Single-Bit Sector ECC Corrector

This block repairs single-bit errors in one sector of flash data held in a byte-wide buffer. A running parity generator, outside this block, supplies a 32-bit raw parity word for the sector. The block squeezes that word into a 24-bit check code, which is stored alongside the data as three bytes. When the sector is read back, the block compares the freshly computed code with the code read from flash and classifies the outcome as clean, corrected, an error in the code itself, or uncorrectable.

On a correctable data error the block reports the byte index and the bit mask to flip. It also repairs the byte in place. It does this with a read-modify-write through a byte-addressed buffer port that has one cycle of read latency. A flipped bit inside the stored code leaves the data untouched. A correctable pattern that points past the end of the sector is treated as uncorrectable.

Top module: `ecc1_sector_fix`

## Requirements
- R1: `code_o` equals the bitwise inverse of `{raw_par_i[27:16], raw_par_i[11:0]}`. Raw bits 31:28 and 15:12 have no effect on it. Byte k of the code (k = 0, 1, 2) sits at bits 8k+7:8k, so the first stored byte is bits 7:0. `stored_code_i` uses the same layout.
- R2: When `cmp_i` is sampled high, `stat_vld_o` is high for exactly the following cycle, with `stat_o` valid: 0 = clean, 1 = corrected, 2 = code error, 3 = uncorrectable. When `cmp_i` is low, `stat_vld_o` is low in the next cycle.
- R3: If the difference d = `code_o` XOR `stored_code_i` is zero, the status is 0 and the buffer is not written.
- R4: If d[23:12] XOR d[11:0] equals 0xFFF and d[23:15] is below SECTOR_BYTES, the status is 1. `fix_idx_o` equals d[23:15], and `fix_mask_o` has a single one at bit position d[14:12].
- R5: If d[23:12] XOR d[11:0] equals 0xFFF but d[23:15] is at least SECTOR_BYTES, the status is 3 and the buffer is not written.
- R6: If d has exactly one bit set, the status is 2 and the buffer is not written.
- R7: Any other nonzero d gives status 3 with no buffer write.
- R8: On status 1, `buf_rd_en_o` is high with `buf_rd_addr_o` = d[23:15] in the cycle in which `stat_vld_o` is high. In the next cycle, `buf_wr_en_o` is high with the same address and `buf_wr_data_o` = `buf_rd_data_i` XOR `fix_mask_o`. Only that byte changes.
- R9: While `rst_n` is low at a clock edge, `stat_vld_o`, `stat_o`, `buf_rd_en_o` and `buf_wr_en_o` are cleared to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| raw_par_i | input | 32 | Raw parity word for the sector |
| code_o | output | 24 | Packed, inverted check code; byte 0 at bits 7:0 |
| cmp_i | input | 1 | Compare strobe |
| stored_code_i | input | 24 | Check code read from flash; byte 0 at bits 7:0 |
| stat_vld_o | output | 1 | Status valid, one cycle after the strobe |
| stat_o | output | 2 | 0 clean, 1 corrected, 2 code error, 3 uncorrectable |
| fix_idx_o | output | 9 | Byte index of the corrected error |
| fix_mask_o | output | 8 | Bit mask to XOR into that byte |
| buf_rd_en_o | output | 1 | Buffer read enable |
| buf_rd_addr_o | output | ADDR_W | Buffer read address (ADDR_W = clog2 SECTOR_BYTES) |
| buf_rd_data_i | input | 8 | Buffer read data, one cycle after the read enable |
| buf_wr_en_o | output | 1 | Buffer write enable |
| buf_wr_addr_o | output | ADDR_W | Buffer write address |
| buf_wr_data_o | output | 8 | Repaired byte |

## Verification
The bench builds the block with SECTOR_BYTES = 64, so ADDR_W is 6. With only 64 bytes in the sector, every byte index and bit position of a correctable error can be swept exhaustively, and each repair can be checked against a bench-side image of the buffer. The same small sector places indices 64 to 511 out of range, so the uncorrectable branch for correctable-looking patterns is reached with many values. All 24 single-bit differences and every two-bit difference are also applied, together with packing patterns that toggle the dropped raw nibbles.

// File: rtl/ecc1_pkg.sv
// Package: shared widths and the status encoding of the sector corrector.
// Assumes a 32-bit raw parity word and a 24-bit stored code split in two 12-bit halves.
package ecc1_pkg;
    localparam int RAW_W   = 32;
    localparam int CODE_W  = 24;
    localparam int HALF_W  = CODE_W / 2;
    localparam int HI_BASE = 16;
    localparam int BIT_W   = 3;
    localparam int IDX_W   = HALF_W - BIT_W;
    localparam int BYTE_W  = 1 << BIT_W;

    typedef enum logic [1:0] {
        ST_CLEAN   = 2'd0,
        ST_FIXED   = 2'd1,
        ST_CODEERR = 2'd2,
        ST_UNCORR  = 2'd3
    } fix_stat_e;
endpackage

// File: rtl/ecc1_code_pack.sv
// Module: compresses the raw parity word into the stored check code.
// Keeps the low half and the half starting at HI_BASE, drops the nibbles
// between them, and inverts the result so an erased page reads consistent.
// Assumes: purely combinational, no state.
module ecc1_code_pack
    import ecc1_pkg::*;
(
    input  logic [RAW_W-1:0]  raw_i,
    output logic [CODE_W-1:0] code_o
);
    // Purpose: pack the kept halves and invert.
    always_comb begin
        code_o = ~{raw_i[HI_BASE +: HALF_W], raw_i[0 +: HALF_W]};
    end
endmodule

// File: rtl/ecc1_syndrome_class.sv
// Module: classifies the difference between calculated and stored codes.
// Complementary halves mean a data error whose position is encoded in the
// upper half; a single set bit means the code itself was hit.
// Assumes: SECTOR_BYTES <= 2**IDX_W; purely combinational.
module ecc1_syndrome_class
    import ecc1_pkg::*;
#(
    parameter int SECTOR_BYTES = 512
) (
    input  logic [CODE_W-1:0] calc_i,
    input  logic [CODE_W-1:0] stored_i,
    output fix_stat_e         stat_o,
    output logic [IDX_W-1:0]  idx_o,
    output logic [BYTE_W-1:0] mask_o
);
    logic [CODE_W-1:0] diff;
    logic              cplm_halves;
    logic              single_bit;
    logic              in_range;

    // Purpose: derive the difference and its shape tests.
    always_comb begin
        diff        = calc_i ^ stored_i;
        cplm_halves = (diff[HALF_W +: HALF_W] ^ diff[0 +: HALF_W]) == {HALF_W{1'b1}};
        single_bit  = (diff != '0) && ((diff & (diff - 1'b1)) == '0);
        idx_o       = diff[CODE_W-1 -: IDX_W];
        mask_o      = BYTE_W'(1) << diff[HALF_W +: BIT_W];
        in_range    = int'(idx_o) < SECTOR_BYTES;
    end

    // Purpose: pick the status in priority order.
    always_comb begin
        if (diff == '0)
            stat_o = ST_CLEAN;
        else if (cplm_halves)
            stat_o = in_range ? ST_FIXED : ST_UNCORR;
        else if (single_bit)
            stat_o = ST_CODEERR;
        else
            stat_o = ST_UNCORR;
    end
endmodule

// File: rtl/ecc1_byte_rmw.sv
// Module: read-modify-write sequencer for one buffer byte.
// Issues a read, then writes the returned byte XOR the latched mask.
// Assumes: the buffer returns read data one cycle after the read enable;
// a start seen while a sequence is running is dropped.
module ecc1_byte_rmw
    import ecc1_pkg::*;
#(
    parameter int ADDR_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [BYTE_W-1:0] mask_i,
    output logic              rd_en_o,
    output logic [ADDR_W-1:0] rd_addr_o,
    input  logic [BYTE_W-1:0] rd_data_i,
    output logic              wr_en_o,
    output logic [ADDR_W-1:0] wr_addr_o,
    output logic [BYTE_W-1:0] wr_data_o
);
    typedef enum logic [1:0] {RMW_IDLE, RMW_READ, RMW_WRITE} rmw_state_e;

    rmw_state_e        state_q;
    logic [ADDR_W-1:0] addr_q;
    logic [BYTE_W-1:0] mask_q;

    // Purpose: step the sequence and latch the target on start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RMW_IDLE;
            addr_q  <= '0;
            mask_q  <= '0;
        end else begin
            case (state_q)
                RMW_IDLE: if (start_i) begin
                    state_q <= RMW_READ;
                    addr_q  <= addr_i;
                    mask_q  <= mask_i;
                end
                RMW_READ:  state_q <= RMW_WRITE;
                default:   state_q <= RMW_IDLE;
            endcase
        end
    end

    // Purpose: drive the buffer port from the current step.
    always_comb begin
        rd_en_o   = state_q == RMW_READ;
        wr_en_o   = state_q == RMW_WRITE;
        rd_addr_o = addr_q;
        wr_addr_o = addr_q;
        wr_data_o = rd_data_i ^ mask_q;
    end
endmodule

// File: rtl/ecc1_sector_fix.sv
// Module: top of the single-bit sector corrector.
// Packs the raw parity, classifies it against the stored code on cmp_i,
// registers the result for one cycle and repairs a correctable byte.
// Assumes: raw_par_i and stored_code_i are valid in the strobe cycle;
// 2 <= SECTOR_BYTES <= 512.
module ecc1_sector_fix
    import ecc1_pkg::*;
#(
    parameter  int SECTOR_BYTES = 512,
    localparam int ADDR_W       = $clog2(SECTOR_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [31:0]       raw_par_i,
    output logic [23:0]       code_o,
    input  logic              cmp_i,
    input  logic [23:0]       stored_code_i,
    output logic              stat_vld_o,
    output logic [1:0]        stat_o,
    output logic [8:0]        fix_idx_o,
    output logic [7:0]        fix_mask_o,
    output logic              buf_rd_en_o,
    output logic [ADDR_W-1:0] buf_rd_addr_o,
    input  logic [7:0]        buf_rd_data_i,
    output logic              buf_wr_en_o,
    output logic [ADDR_W-1:0] buf_wr_addr_o,
    output logic [7:0]        buf_wr_data_o
);
    fix_stat_e         cls_stat;
    logic [IDX_W-1:0]  cls_idx;
    logic [BYTE_W-1:0] cls_mask;
    logic              rmw_start;

    ecc1_code_pack u_pack (
        .raw_i  (raw_par_i),
        .code_o (code_o)
    );

    ecc1_syndrome_class #(.SECTOR_BYTES(SECTOR_BYTES)) u_class (
        .calc_i   (code_o),
        .stored_i (stored_code_i),
        .stat_o   (cls_stat),
        .idx_o    (cls_idx),
        .mask_o   (cls_mask)
    );

    // Purpose: hold the classification for the cycle after the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_vld_o <= 1'b0;
            stat_o     <= ST_CLEAN;
            fix_idx_o  <= '0;
            fix_mask_o <= '0;
        end else begin
            stat_vld_o <= cmp_i;
            if (cmp_i) begin
                stat_o     <= cls_stat;
                fix_idx_o  <= cls_idx;
                fix_mask_o <= cls_mask;
            end
        end
    end

    // Purpose: launch a repair only for a correctable data error.
    always_comb begin
        rmw_start = cmp_i && (cls_stat == ST_FIXED);
    end

    ecc1_byte_rmw #(.ADDR_W(ADDR_W)) u_rmw (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (rmw_start),
        .addr_i    (cls_idx[ADDR_W-1:0]),
        .mask_i    (cls_mask),
        .rd_en_o   (buf_rd_en_o),
        .rd_addr_o (buf_rd_addr_o),
        .rd_data_i (buf_rd_data_i),
        .wr_en_o   (buf_wr_en_o),
        .wr_addr_o (buf_wr_addr_o),
        .wr_data_o (buf_wr_data_o)
    );
endmodule

// File: rtl/ecc1_sector_fix_chk.sv
// Module: property checker for the sector corrector, bound to the top.
// Assumes: the same SECTOR_BYTES as the instance it is bound to.
module ecc1_sector_fix_chk #(
    parameter  int SECTOR_BYTES = 512,
    localparam int ADDR_W       = $clog2(SECTOR_BYTES)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmp_i,
    input logic              stat_vld_o,
    input logic [1:0]        stat_o,
    input logic [8:0]        fix_idx_o,
    input logic [7:0]        fix_mask_o,
    input logic              buf_rd_en_o,
    input logic [ADDR_W-1:0] buf_rd_addr_o,
    input logic              buf_wr_en_o,
    input logic [ADDR_W-1:0] buf_wr_addr_o
);
    assert_vld_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_i |=> stat_vld_o);

    assert_vld_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !cmp_i |=> !stat_vld_o);

    assert_fix_in_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_vld_o && stat_o == 2'd1) |-> (int'(fix_idx_o) < SECTOR_BYTES && $countones(fix_mask_o) == 1));

    assert_rd_only_on_fix_R8: assert property (@(posedge clk) disable iff (!rst_n)
        buf_rd_en_o |-> (stat_vld_o && stat_o == 2'd1 && buf_rd_addr_o == fix_idx_o[ADDR_W-1:0]));

    assert_wr_after_rd_R8: assert property (@(posedge clk) disable iff (!rst_n)
        buf_wr_en_o |-> ($past(buf_rd_en_o) && buf_wr_addr_o == $past(buf_rd_addr_o)));

    assert_port_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({buf_rd_en_o, buf_wr_en_o}));

    // R3, R5, R6, R7: a non-corrected outcome is never followed by a write.
    assert_no_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_vld_o && stat_o != 2'd1) |=> !buf_wr_en_o);
endmodule

bind ecc1_sector_fix ecc1_sector_fix_chk #(.SECTOR_BYTES(SECTOR_BYTES)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cmp_i         (cmp_i),
    .stat_vld_o    (stat_vld_o),
    .stat_o        (stat_o),
    .fix_idx_o     (fix_idx_o),
    .fix_mask_o    (fix_mask_o),
    .buf_rd_en_o   (buf_rd_en_o),
    .buf_rd_addr_o (buf_rd_addr_o),
    .buf_wr_en_o   (buf_wr_en_o),
    .buf_wr_addr_o (buf_wr_addr_o)
);

// File: tb/ecc1_sector_fix_tb.sv
`timescale 1ns/1ps
module ecc1_sector_fix_tb;
    localparam int SB = 64;
    localparam int AW = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [31:0]   raw_par = '0;
    logic [23:0]   code;
    logic          cmp = 1'b0;
    logic [23:0]   stored = '0;
    logic          stat_vld;
    logic [1:0]    stat;
    logic [8:0]    fix_idx;
    logic [7:0]    fix_mask;
    logic          rd_en, wr_en;
    logic [AW-1:0] rd_addr, wr_addr;
    logic [7:0]    rd_data, wr_data;

    logic [7:0]    mem [SB];
    logic [7:0]    exp_mem [SB];
    int            wr_cnt;
    int            checks = 0;
    int            failures = 0;
    bit            done = 1'b0;

    always #2.5 clk = ~clk;

    ecc1_sector_fix #(.SECTOR_BYTES(SB)) u_dut (
        .clk(clk), .rst_n(rst_n), .raw_par_i(raw_par), .code_o(code),
        .cmp_i(cmp), .stored_code_i(stored), .stat_vld_o(stat_vld),
        .stat_o(stat), .fix_idx_o(fix_idx), .fix_mask_o(fix_mask),
        .buf_rd_en_o(rd_en), .buf_rd_addr_o(rd_addr), .buf_rd_data_i(rd_data),
        .buf_wr_en_o(wr_en), .buf_wr_addr_o(wr_addr), .buf_wr_data_o(wr_data)
    );

    // Sector buffer model with one cycle of read latency.
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < SB; i++) mem[i] <= 8'(i * 7 + 3);
            rd_data <= '0;
            wr_cnt  <= 0;
        end else begin
            if (rd_en) rd_data <= mem[rd_addr];
            if (wr_en) begin
                mem[wr_addr] <= wr_data;
                wr_cnt       <= wr_cnt + 1;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [23:0] mk_code(input logic [31:0] r);
        return ~{r[27:16], r[11:0]};
    endfunction

    // Expected status from the difference, following R3..R7.
    function automatic logic [1:0] exp_stat(input logic [23:0] d);
        if (d == 0) return 2'd0;
        if (((d >> 12) ^ d) % 4096 == 4095) return ((d >> 15) < SB) ? 2'd1 : 2'd3;
        if ($countones(d) == 1) return 2'd2;
        return 2'd3;
    endfunction

    task automatic do_cmp(input logic [31:0] raw, input logic [23:0] diff);
        logic [1:0] es;
        int         ei;
        logic [7:0] em;
        int         wc0;
        es = exp_stat(diff);
        ei = int'(diff >> 15);
        em = 8'(1 << ((diff >> 12) % 8));
        @(negedge clk);
        raw_par = raw;
        stored  = mk_code(raw) ^ diff;
        cmp     = 1'b1;
        wc0     = wr_cnt;
        @(negedge clk);
        cmp = 1'b0;
        chk(stat_vld == 1'b1, "R2 valid pulse", 32'(stat_vld), 1);
        chk(stat == es, "R3/R4/R5/R6/R7 status", 32'(stat), 32'(es));
        if (es == 2'd1) begin
            chk(fix_idx == 9'(ei), "R4 index", 32'(fix_idx), 32'(ei));
            chk(fix_mask == em, "R4 mask", 32'(fix_mask), 32'(em));
            chk(rd_en && rd_addr == AW'(ei), "R8 read", 32'({rd_en, rd_addr}), 32'({1'b1, AW'(ei)}));
        end
        @(negedge clk);
        chk(stat_vld == 1'b0, "R2 single cycle", 32'(stat_vld), 0);
        if (es == 2'd1) begin
            chk(wr_en && wr_addr == AW'(ei) && wr_data == (exp_mem[ei] ^ em), "R8 write",
                32'({wr_en, wr_data}), 32'({1'b1, exp_mem[ei] ^ em}));
            exp_mem[ei] = exp_mem[ei] ^ em;
        end
        @(negedge clk);
        if (es == 2'd1) begin
            chk(mem[ei] == exp_mem[ei], "R8 byte repaired", 32'(mem[ei]), 32'(exp_mem[ei]));
            chk(wr_cnt == wc0 + 1, "R8 one write", 32'(wr_cnt), 32'(wc0 + 1));
        end else begin
            chk(wr_cnt == wc0, "R3/R5/R6/R7 no write", 32'(wr_cnt), 32'(wc0));
        end
    endtask

    initial begin
        logic [31:0] x;
        x = 32'h1234_5678;
        for (int i = 0; i < SB; i++) exp_mem[i] = 8'(i * 7 + 3);
        repeat (3) @(negedge clk);
        // R9: reset state
        chk(stat_vld == 0 && stat == 0, "R9 status reset", 32'({stat_vld, stat}), 0);
        chk(rd_en == 0 && wr_en == 0, "R9 port reset", 32'({rd_en, wr_en}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(stat_vld == 0, "R2 idle no pulse", 32'(stat_vld), 0);

        // R1: packing, walking ones and pseudo-random words
        for (int b = 0; b < 32; b++) begin
            raw_par = 32'(1) << b;
            #1;
            chk(code == mk_code(raw_par), "R1 walking bit", 32'(code), 32'(mk_code(raw_par)));
        end
        raw_par = 32'hF000_F000;
        #1;
        chk(code == 24'hFFFFFF, "R1 dropped nibbles", 32'(code), 32'hFFFFFF);
        for (int n = 0; n < 64; n++) begin
            x = x * 32'd1664525 + 32'd1013904223;
            raw_par = x;
            #1;
            chk(code == mk_code(x), "R1 packing", 32'(code), 32'(mk_code(x)));
        end

        // R3: clean compares, including an erased page
        do_cmp(32'h0, 24'h0);
        for (int n = 0; n < 16; n++) begin
            x = x * 32'd1664525 + 32'd1013904223;
            do_cmp(x, 24'h0);
        end

        // R4, R8: every byte and bit of the small sector
        for (int idx = 0; idx < SB; idx++)
            for (int bt = 0; bt < 8; bt++) begin
                logic [11:0] up;
                up = {9'(idx), 3'(bt)};
                x = x * 32'd1664525 + 32'd1013904223;
                do_cmp(x, {up, ~up});
            end

        // R5: correctable shape but index past the sector end
        for (int idx = SB; idx < 512; idx += 7) begin
            logic [11:0] up;
            up = {9'(idx), 3'(idx % 8)};
            do_cmp(x, {up, ~up});
        end
        do_cmp(x, 24'hFFF000);

        // R6: single-bit errors in the stored code
        for (int b = 0; b < 24; b++) do_cmp(x, 24'(1) << b);

        // R7: every two-bit difference
        for (int a = 0; a < 24; a++)
            for (int b = a + 1; b < 24; b++)
                do_cmp(x, (24'(1) << a) | (24'(1) << b));
        do_cmp(x, 24'hABCDEF);

        // R8: only the repaired bytes differ from the initial image
        begin
            bit same;
            same = 1'b1;
            for (int i = 0; i < SB; i++) if (mem[i] != exp_mem[i]) same = 1'b0;
            chk(same, "R8 buffer image", 32'(same), 1);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        done = 1'b1;
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule